// File: doc/BRIEF.md
# Keyslot Lookup Engine

This block searches a shadow store of inline-encryption keyslots for one that already holds exactly the configuration a new request needs, so that the key can be reused instead of programmed again. A request carries a raw key, a key-size code, a flag that selects the split-key (XTS) layout, a capability index and a data-unit mask. The engine arranges the raw key into the same 64-byte layout used when slots are programmed. It then visits the slots from the lowest number upward and reports the first one that is enabled and matches in every field and in every key byte. If no slot matches, it reports a miss, which is kept apart from a malformed-request error.

Every slot comparison walks all sixteen 32-bit words of the key, one word per cycle, before the slot is judged. The elapsed time therefore depends only on which slot hits, never on where a key difference lies. The internal copy of the candidate key is zeroed when the search ends, on a hit and on a miss. A program port writes a slot, and its enable is set by that write. An evict port zeroes every field of one slot.

Top module: `keyslot_lookup`

## Requirements
- R1: After reset `busy`, `done`, `hit` and `err` are 0 and `scratch_clear` is 1.
- R2: A slot that is not enabled never matches. A slot is never enabled after reset or after eviction, and becomes enabled when it is programmed.
- R3: A match requires the stored data-unit mask to equal `req_mask` in all 8 bits. A mask that is a superset of the stored one gives a miss.
- R4: A match requires the stored capability index to equal `req_cap`.
- R5: A match requires all 64 laid-out key bytes to be equal. Size codes 0/1/2/3 mean 16/24/32/64 bytes. Byte i of a key sits at bits [8i+7:8i]. With `xts`=0, the first n raw bytes go to bytes 0..n-1. With `xts`=1, raw bytes 0..n-1 go to bytes 0..n-1 and raw bytes n..2n-1 go to bytes 32..32+n-1. All other bytes are zero. The program port uses the same layout.
- R6: When several slots match, the lowest-numbered slot is reported, with `hit`=1 and its number on `slot_out`.
- R7: When no slot matches, `done` pulses with `hit`=0 and `err`=0.
- R8: A request is rejected when `req_mask` is 0, when `req_cap` is not below NUM_CAPS, or when `req_xts`=1 with size code 3. A rejected request gives `done` with `err`=1 and `hit`=0 one edge after `start` is sampled.
- R9: Counting posedges from the one that samples `start` through the one after which `done` is high, a hit at slot s takes 16(s+1)+1 edges and a miss takes 16·NUM_SLOTS+1 edges. The position of any key difference does not change these counts.
- R10: Eviction zeroes the whole entry of the chosen slot and leaves the other slots intact.
- R11: `scratch_clear` is 0 during a search whose laid-out key is nonzero, and it is 1 from the cycle `done` rises.
- R12: A `start` pulse while `busy` is 1 is ignored, and the running search finishes with its own result.
- R13: `done` stays high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a lookup (sampled while idle) |
| req_key | input | 512 | Raw candidate key, byte i at bits [8i+7:8i] |
| req_xts | input | 1 | Apply split-key layout |
| req_ksz | input | 2 | Key-size code 0..3 = 16/24/32/64 bytes |
| req_cap | input | CAP_W | Requested capability index |
| req_mask | input | 8 | Requested data-unit mask |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Matching slot found |
| err | output | 1 | Request rejected |
| slot_out | output | SLOT_W | Matching slot number (0 when no hit) |
| scratch_clear | output | 1 | Internal candidate copy is all zero |
| prog_we | input | 1 | Write a slot |
| prog_slot | input | SLOT_W | Slot to write |
| prog_key | input | 512 | Raw key to store |
| prog_xts | input | 1 | Split-key layout for the stored key |
| prog_ksz | input | 2 | Key-size code for the stored key |
| prog_cap | input | CAP_W | Capability index to store |
| prog_mask | input | 8 | Data-unit mask to store |
| evict_we | input | 1 | Zero a slot (wins over a write to the same slot) |
| evict_slot | input | SLOT_W | Slot to zero |

## Verification
The bench builds the engine with NUM_SLOTS=4 and NUM_CAPS=4. With four slots, a full miss takes only 65 edges, so every slot position, duplicate entries and the last-slot miss path can all be exercised in a short run. NUM_CAPS=4 places the capability bound inside the 8-bit index field, so the value 4 tests rejection exactly at the edge. The key-layout cases compare the same raw bytes under both layouts, and they flip the first byte and the last byte to show that the latency stays the same.

// File: rtl/klk_pkg.sv
`timescale 1ns/1ps
package klk_pkg;
  localparam int KEY_BYTES  = 64;
  localparam int KEY_BITS   = KEY_BYTES * 8;
  localparam int DWORD_BITS = 32;
  localparam int KEY_DWORDS = KEY_BITS / DWORD_BITS;
  localparam int DW_IDX_W   = $clog2(KEY_DWORDS);
  localparam int MASK_BITS  = 8;
  localparam int HALF_BYTES = KEY_BYTES / 2;

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_state_e;

  // bytes of one key half (or whole key when not split)
  function automatic int key_bytes(logic [1:0] ksz);
    case (ksz)
      2'd0:    return 16;
      2'd1:    return 24;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

  function automatic logic layout_ok(logic xts, logic [1:0] ksz);
    return !(xts && (ksz == 2'd3));
  endfunction

  // arrange a raw key into the stored byte layout
  function automatic logic [KEY_BITS-1:0] layout_key(logic [KEY_BITS-1:0] raw,
                                                     logic xts, logic [1:0] ksz);
    logic [KEY_BITS-1:0] out;
    int n;
    out = '0;
    n = key_bytes(ksz);
    for (int b = 0; b < KEY_BYTES; b++) begin
      if (b < n)
        out[8*b +: 8] = raw[8*b +: 8];
      else if (xts && (b >= HALF_BYTES) && (b < HALF_BYTES + n))
        out[8*b +: 8] = raw[8*(b - HALF_BYTES + n) +: 8];
    end
    return out;
  endfunction

  function automatic logic [DWORD_BITS-1:0] dword_of(logic [KEY_BITS-1:0] key,
                                                     logic [DW_IDX_W-1:0] idx);
    return key[DWORD_BITS*idx +: DWORD_BITS];
  endfunction
endpackage

// File: rtl/klk_store.sv
`timescale 1ns/1ps
module klk_store
  import klk_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CAP_W     = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  input  logic [MASK_BITS-1:0] wr_mask,
  input  logic [CAP_W-1:0]     wr_cap,
  input  logic [KEY_BITS-1:0]  wr_key,
  input  logic                 ev_en,
  input  logic [SLOT_W-1:0]    ev_slot,
  input  logic [SLOT_W-1:0]    rd_slot,
  output logic                 rd_en,
  output logic [MASK_BITS-1:0] rd_mask,
  output logic [CAP_W-1:0]     rd_cap,
  output logic [KEY_BITS-1:0]  rd_key,
  output logic [NUM_SLOTS-1:0] en_vec
);
  logic [MASK_BITS-1:0] mask_a [NUM_SLOTS];
  logic [CAP_W-1:0]     cap_a  [NUM_SLOTS];
  logic [KEY_BITS-1:0]  key_a  [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic                 en_q;
    logic [MASK_BITS-1:0] mask_q;
    logic [CAP_W-1:0]     cap_q;
    logic [KEY_BITS-1:0]  key_q;
    wire hit_ev = ev_en && (ev_slot == SLOT_W'(g));
    wire hit_wr = wr_en && (wr_slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0; mask_q <= '0; cap_q <= '0; key_q <= '0;
      end else if (hit_ev) begin
        en_q <= 1'b0; mask_q <= '0; cap_q <= '0; key_q <= '0;
      end else if (hit_wr) begin
        en_q <= 1'b1; mask_q <= wr_mask; cap_q <= wr_cap; key_q <= wr_key;
      end
    end

    assign en_vec[g] = en_q;
    assign mask_a[g] = mask_q;
    assign cap_a[g]  = cap_q;
    assign key_a[g]  = key_q;
  end

  assign rd_en   = en_vec[rd_slot];
  assign rd_mask = mask_a[rd_slot];
  assign rd_cap  = cap_a[rd_slot];
  assign rd_key  = key_a[rd_slot];
endmodule

// File: rtl/klk_cmp.sv
`timescale 1ns/1ps
module klk_cmp
  import klk_pkg::*;
#(
  parameter int CAP_W = 8
) (
  input  logic [KEY_BITS-1:0]  cand_key,
  input  logic [KEY_BITS-1:0]  slot_key,
  input  logic [DW_IDX_W-1:0]  dw_idx,
  input  logic                 slot_en,
  input  logic [MASK_BITS-1:0] slot_mask,
  input  logic [CAP_W-1:0]     slot_cap,
  input  logic [MASK_BITS-1:0] want_mask,
  input  logic [CAP_W-1:0]     want_cap,
  output logic                 dw_eq,
  output logic                 hdr_eq
);
  logic [DWORD_BITS-1:0] diff;

  // one word per cycle; no early exit on mismatch
  assign diff   = dword_of(cand_key, dw_idx) ^ dword_of(slot_key, dw_idx);
  assign dw_eq  = (diff == '0);
  assign hdr_eq = slot_en && (slot_mask == want_mask) && (slot_cap == want_cap);
endmodule

// File: rtl/klk_scan.sv
`timescale 1ns/1ps
module klk_scan
  import klk_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CAP_W     = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 req_ok,
  input  logic [KEY_BITS-1:0]  lay_key,
  input  logic [CAP_W-1:0]     req_cap,
  input  logic [MASK_BITS-1:0] req_mask,
  input  logic                 dw_eq,
  input  logic                 hdr_eq,
  output logic [SLOT_W-1:0]    cur_slot,
  output logic [DW_IDX_W-1:0]  cur_dw,
  output logic [KEY_BITS-1:0]  cand_key,
  output logic [CAP_W-1:0]     want_cap,
  output logic [MASK_BITS-1:0] want_mask,
  output logic                 busy,
  output logic                 done,
  output logic                 hit,
  output logic                 err,
  output logic [SLOT_W-1:0]    slot_out,
  output logic                 ev_match,
  output logic                 ev_exhaust
);
  localparam logic [DW_IDX_W-1:0] DW_LAST   = DW_IDX_W'(KEY_DWORDS - 1);
  localparam logic [SLOT_W-1:0]   SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  scan_state_e          st_q;
  logic [SLOT_W-1:0]    slot_q, slot_out_q;
  logic [DW_IDX_W-1:0]  dw_q;
  logic                 acc_q, done_q, hit_q, err_q;
  logic [KEY_BITS-1:0]  cand_q;
  logic [CAP_W-1:0]     cap_q;
  logic [MASK_BITS-1:0] mask_q;
  logic                 last_dw, slot_match;

  assign last_dw    = (st_q == ST_SCAN) && (dw_q == DW_LAST);
  assign slot_match = acc_q && dw_eq && hdr_eq;
  assign ev_match   = last_dw && slot_match;
  assign ev_exhaust = last_dw && !slot_match && (slot_q == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; slot_q <= '0; dw_q <= '0; acc_q <= 1'b1;
      cand_q <= '0; cap_q <= '0; mask_q <= '0;
      done_q <= 1'b0; hit_q <= 1'b0; err_q <= 1'b0; slot_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            hit_q <= 1'b0;
            slot_out_q <= '0;
            if (!req_ok) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              err_q  <= 1'b0;
              st_q   <= ST_SCAN;
              cand_q <= lay_key;
              cap_q  <= req_cap;
              mask_q <= req_mask;
              slot_q <= '0;
              dw_q   <= '0;
              acc_q  <= 1'b1;
            end
          end
        end
        ST_SCAN: begin
          if (dw_q != DW_LAST) begin
            acc_q <= acc_q & dw_eq;
            dw_q  <= dw_q + 1'b1;
          end else if (slot_match) begin
            done_q <= 1'b1; hit_q <= 1'b1; slot_out_q <= slot_q;
            st_q <= ST_IDLE; cand_q <= '0;
          end else if (slot_q == SLOT_LAST) begin
            done_q <= 1'b1; hit_q <= 1'b0; slot_out_q <= '0;
            st_q <= ST_IDLE; cand_q <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
            dw_q   <= '0;
            acc_q  <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_slot  = slot_q;
  assign cur_dw    = dw_q;
  assign cand_key  = cand_q;
  assign want_cap  = cap_q;
  assign want_mask = mask_q;
  assign busy      = (st_q == ST_SCAN);
  assign done      = done_q;
  assign hit       = hit_q;
  assign err       = err_q;
  assign slot_out  = slot_out_q;
endmodule

// File: rtl/keyslot_lookup.sv
`timescale 1ns/1ps
module keyslot_lookup
  import klk_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_CAPS  = 4,
  parameter int CAP_W     = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [KEY_BITS-1:0]  req_key,
  input  logic                 req_xts,
  input  logic [1:0]           req_ksz,
  input  logic [CAP_W-1:0]     req_cap,
  input  logic [MASK_BITS-1:0] req_mask,
  output logic                 busy,
  output logic                 done,
  output logic                 hit,
  output logic                 err,
  output logic [SLOT_W-1:0]    slot_out,
  output logic                 scratch_clear,
  input  logic                 prog_we,
  input  logic [SLOT_W-1:0]    prog_slot,
  input  logic [KEY_BITS-1:0]  prog_key,
  input  logic                 prog_xts,
  input  logic [1:0]           prog_ksz,
  input  logic [CAP_W-1:0]     prog_cap,
  input  logic [MASK_BITS-1:0] prog_mask,
  input  logic                 evict_we,
  input  logic [SLOT_W-1:0]    evict_slot
);
  // named internal events for the checker
  logic                 req_bad;
  logic                 ev_match, ev_exhaust;
  logic [NUM_SLOTS-1:0] en_vec;

  logic [SLOT_W-1:0]    cur_slot;
  logic [DW_IDX_W-1:0]  cur_dw;
  logic [KEY_BITS-1:0]  cand_key, rd_key, lay_req, lay_prog;
  logic [CAP_W-1:0]     want_cap, rd_cap;
  logic [MASK_BITS-1:0] want_mask, rd_mask;
  logic                 rd_en, dw_eq, hdr_eq;

  assign lay_req  = layout_key(req_key, req_xts, req_ksz);
  assign lay_prog = layout_key(prog_key, prog_xts, prog_ksz);
  assign req_bad  = (req_mask == '0) || (32'(req_cap) >= NUM_CAPS) ||
                    !layout_ok(req_xts, req_ksz);

  klk_store #(.NUM_SLOTS(NUM_SLOTS), .CAP_W(CAP_W), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prog_we), .wr_slot(prog_slot), .wr_mask(prog_mask),
    .wr_cap(prog_cap), .wr_key(lay_prog),
    .ev_en(evict_we), .ev_slot(evict_slot),
    .rd_slot(cur_slot), .rd_en(rd_en), .rd_mask(rd_mask),
    .rd_cap(rd_cap), .rd_key(rd_key), .en_vec(en_vec)
  );

  klk_cmp #(.CAP_W(CAP_W)) u_cmp (
    .cand_key(cand_key), .slot_key(rd_key), .dw_idx(cur_dw),
    .slot_en(rd_en), .slot_mask(rd_mask), .slot_cap(rd_cap),
    .want_mask(want_mask), .want_cap(want_cap),
    .dw_eq(dw_eq), .hdr_eq(hdr_eq)
  );

  klk_scan #(.NUM_SLOTS(NUM_SLOTS), .CAP_W(CAP_W), .SLOT_W(SLOT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ok(!req_bad),
    .lay_key(lay_req), .req_cap(req_cap), .req_mask(req_mask),
    .dw_eq(dw_eq), .hdr_eq(hdr_eq),
    .cur_slot(cur_slot), .cur_dw(cur_dw), .cand_key(cand_key),
    .want_cap(want_cap), .want_mask(want_mask),
    .busy(busy), .done(done), .hit(hit), .err(err), .slot_out(slot_out),
    .ev_match(ev_match), .ev_exhaust(ev_exhaust)
  );

  assign scratch_clear = (cand_key == '0);
endmodule

// File: rtl/klk_checker.sv
`timescale 1ns/1ps
module klk_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 hit,
  input logic                 err,
  input logic [SLOT_W-1:0]    slot_out,
  input logic                 scratch_clear,
  input logic                 req_bad,
  input logic                 ev_match,
  input logic                 ev_exhaust,
  input logic [NUM_SLOTS-1:0] en_vec
);
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && $stable(en_vec)) |-> en_vec[slot_out]); // R2
  AST_MISS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exhaust |=> (done && !hit && !err)); // R7
  AST_REJECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && req_bad) |=> (done && err && !hit)); // R8
  AST_SCAN_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !req_bad) |=> (busy && !done)); // R9
  AST_MATCH_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> (done && hit && !busy)); // R6
  AST_WIPED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> scratch_clear); // R11
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ev_match && !ev_exhaust) |=> (busy && !done)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13
endmodule

bind keyslot_lookup klk_checker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .hit(hit), .err(err), .slot_out(slot_out), .scratch_clear(scratch_clear),
  .req_bad(req_bad), .ev_match(ev_match), .ev_exhaust(ev_exhaust),
  .en_vec(en_vec)
);

// File: tb/keyslot_lookup_test.sv
`timescale 1ns/1ps
module keyslot_lookup_test;
  localparam int NS  = 4;
  localparam int NC  = 4;
  localparam int CW  = 8;
  localparam int SW  = 2;
  localparam int KB  = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 0, req_xts = 0, prog_we = 0, prog_xts = 0, evict_we = 0;
  logic [KB-1:0] req_key = '0, prog_key = '0;
  logic [1:0]    req_ksz = 0, prog_ksz = 0;
  logic [CW-1:0] req_cap = 0, prog_cap = 0;
  logic [7:0]    req_mask = 0, prog_mask = 0;
  logic [SW-1:0] prog_slot = 0, evict_slot = 0;
  logic          busy, done, hit, err, scratch_clear;
  logic [SW-1:0] slot_out;

  keyslot_lookup #(.NUM_SLOTS(NS), .NUM_CAPS(NC), .CAP_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_key(req_key),
    .req_xts(req_xts), .req_ksz(req_ksz), .req_cap(req_cap), .req_mask(req_mask),
    .busy(busy), .done(done), .hit(hit), .err(err), .slot_out(slot_out),
    .scratch_clear(scratch_clear),
    .prog_we(prog_we), .prog_slot(prog_slot), .prog_key(prog_key),
    .prog_xts(prog_xts), .prog_ksz(prog_ksz), .prog_cap(prog_cap),
    .prog_mask(prog_mask), .evict_we(evict_we), .evict_slot(evict_slot)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // bench model of the store
  bit            m_en   [NS];
  logic [7:0]    m_mask [NS];
  logic [CW-1:0] m_cap  [NS];
  logic [KB-1:0] m_key  [NS];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] k);
    return (k == 0) ? 16 : (k == 1) ? 24 : (k == 2) ? 32 : 64;
  endfunction

  // R5 layout computed with shifts and masks
  function automatic logic [KB-1:0] m_layout(logic [KB-1:0] raw, logic x, logic [1:0] k);
    logic [KB-1:0] one = 1;
    logic [KB-1:0] m;
    int n = nbytes(k);
    m = (n == 64) ? ~('0) : ((one << (8*n)) - 1);
    if (x) return (raw & m) | (((raw >> (8*n)) & m) << 256);
    return raw & m;
  endfunction

  function automatic logic [KB-1:0] kgen(int seed);
    logic [KB-1:0] k;
    for (int i = 0; i < 16; i++)
      k[32*i +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h01000193 + 32'h5A;
    return k;
  endfunction

  task automatic do_prog(input int s, input logic [KB-1:0] raw, input logic x,
                         input logic [1:0] k, input logic [CW-1:0] c, input logic [7:0] mk);
    @(negedge clk);
    prog_we = 1; prog_slot = SW'(s); prog_key = raw; prog_xts = x;
    prog_ksz = k; prog_cap = c; prog_mask = mk;
    @(negedge clk);
    prog_we = 0;
    m_en[s] = 1; m_mask[s] = mk; m_cap[s] = c; m_key[s] = m_layout(raw, x, k);
  endtask

  task automatic do_evict(input int s);
    @(negedge clk);
    evict_we = 1; evict_slot = SW'(s);
    @(negedge clk);
    evict_we = 0;
    m_en[s] = 0; m_mask[s] = 0; m_cap[s] = 0; m_key[s] = '0;
  endtask

  task automatic lookup(input logic [KB-1:0] raw, input logic x, input logic [1:0] k,
                        input logic [CW-1:0] c, input logic [7:0] mk,
                        input string tag, input bit poke);
    bit e_err;
    int e_slot, e_lat, n;
    logic [KB-1:0] lk;
    e_err = (mk == 0) || (int'(c) >= NC) || (x && k == 3);
    lk = m_layout(raw, x, k);
    e_slot = -1;
    if (!e_err)
      for (int s = NS - 1; s >= 0; s--)
        if (m_en[s] && m_mask[s] == mk && m_cap[s] == c && m_key[s] == lk) e_slot = s;
    e_lat = e_err ? 1 : (e_slot >= 0) ? 16 * (e_slot + 1) + 1 : 16 * NS + 1;
    @(negedge clk);
    start = 1; req_key = raw; req_xts = x; req_ksz = k; req_cap = c; req_mask = mk;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      start = 0;
      if (n == 1 && !e_err) begin
        chk(busy === 1'b1, {tag, " R9 busy"}, 64'(busy), 1);
        chk(scratch_clear === (lk == '0), "R11 scratch during search",
            64'(scratch_clear), 64'(lk == '0));
      end
      if (poke && n == 3) begin start = 1; req_mask = 0; end
      if (poke && n == 4) req_mask = mk;
    end while (!done && n < 2000);
    chk(n == e_lat, {tag, " R9 latency"}, 64'(n), 64'(e_lat));
    chk(err === e_err, {tag, " err"}, 64'(err), 64'(e_err));
    chk(hit === (e_slot >= 0), {tag, " hit"}, 64'(hit), 64'(e_slot >= 0));
    if (e_slot >= 0) chk(slot_out == SW'(e_slot), {tag, " R6 slot"}, 64'(slot_out), 64'(e_slot));
    chk(scratch_clear === 1'b1, "R11 scratch wiped", 64'(scratch_clear), 1);
    @(negedge clk);
    chk(done === 1'b0, "R13 done pulse", 64'(done), 0);
  endtask

  task automatic t_reset;
    chk(busy === 0 && done === 0 && hit === 0 && err === 0, "R1 reset outputs",
        {60'd0, busy, done, hit, err}, 0);
    chk(scratch_clear === 1, "R1 reset scratch", 64'(scratch_clear), 1);
  endtask

  task automatic t_empty;
    lookup(kgen(1), 1, 0, 1, 8'h08, "R2 empty store miss", 0);
  endtask

  task automatic t_first_match;
    lookup(kgen(1), 1, 0, 1, 8'h08, "R6 first of duplicates", 0);
    lookup(kgen(3), 0, 1, 0, 8'h02, "R6 slot3", 0);
  endtask

  task automatic t_fields;
    lookup(kgen(2), 0, 3, 2, 8'h01, "R5 exact key hit", 0);
    lookup(kgen(2), 0, 3, 2, 8'h03, "R3 superset mask", 0);
    lookup(kgen(2), 0, 3, 3, 8'h01, "R4 cap differs", 0);
    lookup(kgen(2) ^ 512'hFF, 0, 3, 2, 8'h01, "R5 first byte", 0);
    lookup(kgen(2) ^ (512'hFF << 504), 0, 3, 2, 8'h01, "R5 last byte", 0);
    lookup(kgen(1), 0, 2, 1, 8'h08, "R5 layout differs", 0);
    lookup(kgen(1) & ((512'd1 << 256) - 1), 1, 2, 1, 8'h04, "R7 miss status", 0);
  endtask

  task automatic t_evict;
    do_evict(0);
    lookup(kgen(1), 1, 0, 1, 8'h08, "R10 evicted falls to dup", 0);
    lookup(kgen(3), 0, 1, 0, 8'h02, "R10 neighbour intact", 0);
    do_evict(1);
    lookup(kgen(2), 0, 3, 2, 8'h01, "R2 evicted slot disabled", 0);
    do_prog(1, kgen(2), 0, 3, 2, 8'h01);
    lookup(kgen(2), 0, 3, 2, 8'h01, "R2 reprogrammed", 0);
  endtask

  task automatic t_reject;
    lookup(kgen(2), 0, 3, 2, 8'h00, "R8 zero mask", 0);
    lookup(kgen(2), 0, 3, 4, 8'h01, "R8 cap at bound", 0);
    lookup(kgen(2), 1, 3, 2, 8'h01, "R8 split 64-byte", 0);
  endtask

  task automatic t_busy;
    lookup(kgen(3), 0, 1, 0, 8'h02, "R12 start while busy", 1);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_en[s] = 0; m_mask[s] = 0; m_cap[s] = 0; m_key[s] = '0;
    end
    #1;
    t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_empty;
    do_prog(0, kgen(1), 1, 0, 1, 8'h08);
    do_prog(1, kgen(2), 0, 3, 2, 8'h01);
    do_prog(2, kgen(1), 1, 0, 1, 8'h08);
    do_prog(3, kgen(3), 0, 1, 0, 8'h02);
    t_first_match;
    t_fields;
    t_evict;
    t_reject;
    t_busy;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule